// File: doc/BRIEF.md
# Hysteretic AND/OR Gate State Machine

This block is a clocked gate whose function is chosen by a remembered mode. It has two data inputs and one output. In AND mode the output is the AND of the two inputs; in OR mode it is their OR. The mode moves only when the inputs agree. Both inputs high puts the block in AND mode, and both inputs low puts it in OR mode. Any mixed pair leaves the mode as it was. The result is a gate with hysteresis: a mixed input pair reads as 0 after both inputs were last seen high, and as 1 after both inputs were last seen low.

Each input passes through its own synchronizing flip-flop before it reaches any logic, so the data inputs may change at any time. A parameter picks the output style. The Mealy style stores only the mode bit and forms the output from that bit and the synchronized inputs. The Moore style stores the mode and the output value in two flip-flops and drives the output straight from the second one. As a result the Moore output lags the Mealy output by one clock. Reset is synchronous and active high.

Top module: `hyst_gate_fsm`

## Requirements
- R1: A synchronized input pair of 1,1 sets AND mode. The block keeps AND mode until a synchronized pair of 0,0 is seen, so a mixed pair that follows gives an output of 0.
- R2: A synchronized input pair of 0,0 sets OR mode. The block keeps OR mode until a synchronized pair of 1,1 is seen, so a mixed pair that follows gives an output of 1.
- R3: In AND mode the output is a_in AND b_in. In OR mode it is a_in OR b_in. When both inputs are equal, the output is equal to them.
- R4: The mixed pairs 0,1 and 1,0 never change the mode, whether they come singly or in a run. This holds in both modes and for both output styles.
- R5: With MOORE_OUT = 0 (Mealy), the output reflects a pair of inputs from the first rising edge at which that pair is present.
- R6: With MOORE_OUT = 1 (Moore), the output comes from a state register and reflects a pair of inputs one rising edge later than the Mealy style does.
- R7: A rising edge with rst high clears the synchronizers, selects OR mode and forces the output to 0 in both styles. This holds even while both inputs are 1.
- R8: A change on a_in or b_in between rising edges does not reach f_out before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | First data input. May be asynchronous |
| b_in | input | 1 | Second data input. May be asynchronous |
| f_out | output | 1 | Gated output: AND or OR of the inputs, according to the mode |

## Verification
A pair of inputs driven before rising edge k is due on the Mealy output after edge k, and on the Moore output after edge k+1. The Moore result for a pair therefore shows at the sample point where the Mealy result for the next pair shows. The bench drives inputs on falling edges and samples both variants at the following falling edge. It compares the Mealy output with the expected value for the current vector and the Moore output with the expected value for the previous one. The bound checks use the same lags: one cycle back into the input history for Mealy and two for Moore. They act only once enough cycles since reset have passed to fill that history.

// File: rtl/hyst_gate_fsm.sv
module hyst_gate_fsm #(
  parameter bit MOORE_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic a_in,
  input  logic b_in,
  output logic f_out
);

  logic a_q, b_q;
  logic mode_q;
  logic mode_d;
  logic both_hi, both_lo, any_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  assign both_hi = a_q & b_q;
  assign any_hi  = a_q | b_q;
  assign both_lo = ~any_hi;

  // mode_q: 1 = AND mode, 0 = OR mode
  assign mode_d = both_hi ? 1'b1 : (both_lo ? 1'b0 : mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= mode_d;
  end

  generate
    if (MOORE_OUT) begin : g_moore
      logic out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= mode_d ? both_hi : any_hi;
      end
      assign f_out = out_q;
    end else begin : g_mealy
      assign f_out = mode_q ? both_hi : any_hi;
    end
  endgenerate

endmodule

// File: rtl/hyst_gate_fsm_chk.sv
module hyst_gate_fsm_chk #(
  parameter bit MOORE_OUT = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic a_in,
  input logic b_in,
  input logic f_out
);

  localparam int LAT = MOORE_OUT ? 2 : 1;

  logic [2:0] since_rst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 3'd0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  assign warm = (since_rst >= 3'(LAT + 3));

  generate
    if (MOORE_OUT) begin : g_lat2
      a_r3_equal_pair: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(a_in, 2) == $past(b_in, 2)) |-> (f_out == $past(a_in, 2)));
      a_r1_and_holds: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(a_in && b_in, 3) && $past(a_in != b_in, 2)) |-> !f_out);
      a_r2_or_holds: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(!a_in && !b_in, 3) && $past(a_in != b_in, 2)) |-> f_out);
      a_r4_mixed_keep: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(a_in != b_in, 3) && $past(a_in != b_in, 2)) |-> (f_out == $past(f_out)));
    end else begin : g_lat1
      a_r3_equal_pair: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(a_in) == $past(b_in)) |-> (f_out == $past(a_in)));
      a_r1_and_holds: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(a_in && b_in, 2) && $past(a_in != b_in)) |-> !f_out);
      a_r2_or_holds: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(!a_in && !b_in, 2) && $past(a_in != b_in)) |-> f_out);
      a_r4_mixed_keep: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(a_in != b_in, 2) && $past(a_in != b_in)) |-> (f_out == $past(f_out)));
    end
  endgenerate

  a_r7_reset_clears: assert property (@(posedge clk) rst |=> !f_out);

endmodule

bind hyst_gate_fsm hyst_gate_fsm_chk #(.MOORE_OUT(MOORE_OUT)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .f_out(f_out)
);

// File: tb/hyst_gate_fsm_bench.sv
module hyst_gate_fsm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  // each entry: {a, b, expected Mealy f}
  localparam logic [2:0] VEC [NVEC] = '{
    3'b000, 3'b011, 3'b101, 3'b111, 3'b010, 3'b100, 3'b000, 3'b101,
    3'b011, 3'b111, 3'b111, 3'b100, 3'b000, 3'b000, 3'b011, 3'b111
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a = 1'b1;
  logic b = 1'b1;
  logic f_mealy, f_moore;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hyst_gate_fsm #(.MOORE_OUT(1'b0)) u_hyst_gate_fsm (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b), .f_out(f_mealy));
  hyst_gate_fsm #(.MOORE_OUT(1'b1)) u_hyst_gate_fsm_moore (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b), .f_out(f_moore));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic prev;
    // R7: reset held with both inputs high
    repeat (3) @(negedge clk);
    check("R7 mealy reset", f_mealy, 1'b0);
    check("R7 moore reset", f_moore, 1'b0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6: vector walk
    prev = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      a = VEC[i][2];
      b = VEC[i][1];
      @(negedge clk);
      check("R5 mealy vector", f_mealy, VEC[i][0]);
      check("R6 moore vector", f_moore, prev);
      prev = VEC[i][0];
    end

    // R8: mid-cycle change in AND mode, then R4/R1 mixed pair gives 0
    a = 1'b0; b = 1'b1;
    #2;
    check("R8 mealy mid-cycle", f_mealy, 1'b1);
    check("R8 moore mid-cycle", f_moore, 1'b1);
    @(negedge clk);
    check("R1 mealy and-mode mixed", f_mealy, 1'b0);
    check("R6 moore lag", f_moore, 1'b1);
    a = 1'b1; b = 1'b0;
    @(negedge clk);
    check("R4 mealy run of mixed", f_mealy, 1'b0);
    check("R1 moore and-mode mixed", f_moore, 1'b0);

    // R7: reset out of AND mode returns to OR mode
    a = 1'b1; b = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R7 mealy reset from and", f_mealy, 1'b0);
    check("R7 moore reset from and", f_moore, 1'b0);
    rst = 1'b0;
    a = 1'b1; b = 1'b0;
    @(negedge clk);
    check("R7 mealy or-mode after reset", f_mealy, 1'b1);
    check("R7 moore sync cleared", f_moore, 1'b0);
    @(negedge clk);
    check("R2 moore or-mode after reset", f_moore, 1'b1);

    // R2 R4: OR mode held across a run of mixed pairs
    a = 1'b0; b = 1'b0;
    @(negedge clk);
    check("R3 mealy 00", f_mealy, 1'b0);
    a = 1'b0; b = 1'b1;
    @(negedge clk);
    check("R2 mealy or-mode mixed", f_mealy, 1'b1);
    a = 1'b1; b = 1'b0;
    @(negedge clk);
    check("R4 mealy or kept", f_mealy, 1'b1);
    check("R4 moore or kept", f_moore, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule